// File: doc/BRIEF.md
# SD Command-Line Transceiver

This block runs one command exchange on the command line of an SD card in native one-bit mode. A single start pulse begins the exchange. The block first clocks the card with the line released. It then waits, with a time limit, for the card to let the line float high. After one more idle clock it shifts out the caller's command bytes. The caller supplies these bytes complete, with the CRC7 and the end bit already in place. When a response is wanted, the block waits for the card to pull the line low and gathers the reply bytes.

The command bytes come from a small buffer owned by the caller. The block presents a byte index, and the buffer returns that byte on `cmd_byte`. Each response byte appears on `rsp_byte` together with a one-cycle `rsp_valid` strobe. At the end a one-cycle `done` pulse carries a two-bit outcome: 0 for success, 1 when the card never released the line, 2 when no response began. The SD clock comes from the system clock through a divider that the caller programs, and it stays low between exchanges. CRC checking, the data lines and the card start-up sequence are handled elsewhere.

Top module: `sd_cmd_xcvr`

## Requirements
- R1: After `start`, the first 8 rising SD clock edges pass with `cmd_oe` low. The line value seen on those edges has no effect.
- R2: From the 9th rising edge, CMD is sampled on every rising edge until it reads 1. If the 1024th such sample still reads 0, the exchange ends with result 1 and nothing is transmitted.
- R3: Exactly one rising edge passes with `cmd_oe` low between the rising edge that saw CMD high and the first command bit.
- R4: The command is `cmd_len` bytes, sent MSB first, one bit per SD clock. Each bit is driven on the falling SD clock edge with `cmd_oe` high, and it is stable at the next rising edge. Byte n is read from `cmd_byte` while `cmd_idx` equals n.
- R5: After the last command bit, `cmd_oe` drops at the next falling edge, and two rising edges pass for turnaround. If `rsp_len` is 0, `done` follows the second of these with result 0.
- R6: Otherwise CMD is sampled on each following rising edge until it reads 0. If the 1024th sample still reads 1, the exchange ends with result 2.
- R7: The low sample that ends the wait is bit 7 (value 0) of response byte 0. Every later bit is sampled on a rising edge and shifted in MSB first. `rsp_valid` pulses for one system clock after the rising edge that completes each byte, with the byte on `rsp_byte`. There are `rsp_len` bytes, at most 17.
- R8: After the last response byte, two more rising edges pass. Then `done` pulses with result 0.
- R9: While running, each SD clock half-period lasts `clk_div`+1 system clocks. From the cycle after the block returns to idle, `sd_clk` is held low.
- R10: `cmd_oe` is high only while command bits are being driven. It is low when the block is idle, waiting or receiving, and `cmd_o` reads 1 while released.
- R11: `done` is a single-cycle pulse. It comes in the cycle right after the final rising edge of the exchange, and no SD clock edge follows it. `result` is 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an exchange (taken when idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| rsp_len | input | LEN_W | Response length in bytes, 0 for none |
| clk_div | input | DIV_W | SD clock half-period minus one, in system clocks |
| cmd_byte | input | 8 | Command byte selected by `cmd_idx` |
| cmd_idx | output | LEN_W | Index of the command byte being fetched |
| rsp_byte | output | 8 | Last completed response byte |
| rsp_valid | output | 1 | One-cycle strobe per completed response byte |
| done | output | 1 | One-cycle end-of-exchange pulse |
| result | output | 2 | Outcome: 0 ok, 1 line held low, 2 no response |
| sd_clk | output | 1 | SD card clock |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_i | input | 1 | CMD line as seen at the pad |

## Verification
Every result is tied to a rising SD clock edge. The state of the command line, `rsp_valid` with its byte, and `done` with its code are all due in the system cycle that follows the edge on which `sd_clk` rises, so the reference model numbers the rising edges of each exchange and checks on the half-cycle after each one. For every exchange the model lists, edge by edge, the expected drive value, drive enable, card answer and strobe. Every half-period is timed against `clk_div`+1, and every cycle with no rising edge is checked for the absence of `rsp_valid` and `done`.

// File: rtl/sd_cmd_pkg.sv
// Shared types for the SD command-line transceiver.
// Assumes: one exchange at a time, sequenced by sd_cmd_ctrl.
package sd_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_HI,
        ST_GAP,
        ST_TX,
        ST_TURN,
        ST_WAIT_LO,
        ST_RX,
        ST_TAIL
    } cmd_state_t;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_BUSY  = 2'd1;
    localparam logic [1:0] RES_NORSP = 2'd2;

endpackage

// File: rtl/sd_clk_gen.sv
// SD clock divider. Toggles sd_clk every div+1 system clocks while enabled.
// Flags the system cycle in which the clock will rise or fall at the next edge.
// Assumes: div is stable while en is high. Clock forced low when disabled.
module sd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sd_clk,
    output logic             rise_ev,
    output logic             fall_ev
);

    logic [DIV_W-1:0] cnt;
    logic             tc;

    // Terminal count of the half-period
    assign tc      = (cnt == div);
    assign rise_ev = en && tc && !sd_clk;
    assign fall_ev = en && tc && sd_clk;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sd_clk <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            sd_clk <= 1'b0;
        end else if (tc) begin
            cnt    <= '0;
            sd_clk <= ~sd_clk;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sd_cmd_tx.sv
// Command serializer. On each falling SD clock event it drives the next bit,
// MSB first, taking a new byte from cmd_byte (selected by cmd_idx) every 8 bits.
// Releases the line (oe low, value 1) on any falling event outside transmit.
// Assumes: cmd_byte is valid one system cycle after cmd_idx changes.
module sd_cmd_tx #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tx_en,
    input  logic             fall_ev,
    input  logic [7:0]       cmd_byte,
    input  logic [LEN_W-1:0] cmd_len,
    output logic [LEN_W-1:0] cmd_idx,
    output logic             cmd_o,
    output logic             cmd_oe,
    output logic             tx_last
);

    logic [6:0]       sh;
    logic [2:0]       bitpos;
    logic [LEN_W-1:0] bidx;

    // All bytes sent once the index runs past the count on a byte boundary
    assign tx_last = (bitpos == 3'd0) && (bidx == cmd_len);
    assign cmd_idx = bidx;

    // Bit shifter and line driver, updated on falling SD edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            bitpos <= '0;
            bidx   <= '0;
            cmd_o  <= 1'b1;
            cmd_oe <= 1'b0;
        end else if (clr) begin
            bitpos <= '0;
            bidx   <= '0;
            cmd_o  <= 1'b1;
            cmd_oe <= 1'b0;
        end else if (fall_ev) begin
            if (tx_en) begin
                cmd_oe <= 1'b1;
                if (bitpos == 3'd0) begin
                    cmd_o <= cmd_byte[7];
                    sh    <= cmd_byte[6:0];
                end else begin
                    cmd_o <= sh[6];
                    sh    <= {sh[5:0], 1'b0};
                end
                bitpos <= bitpos + 1'b1;
                if (bitpos == 3'd7) begin
                    bidx <= bidx + 1'b1;
                end
            end else begin
                cmd_oe <= 1'b0;
                cmd_o  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sd_cmd_rx.sv
// Response deserializer. Seeded by the start bit as bit 7 of the first byte,
// then shifts one bit per rising SD edge, MSB first, and strobes each byte.
// Assumes: rx_start and rx_en are never high together.
module sd_cmd_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_ev,
    input  logic       rx_start,
    input  logic       rx_en,
    input  logic       cmd_i,
    output logic [7:0] rsp_byte,
    output logic       rsp_valid,
    output logic       byte_end
);

    logic [6:0] sh;
    logic [2:0] cnt;

    // Eighth bit of a byte arrives on this rising edge
    assign byte_end = rx_en && rise_ev && (cnt == 3'd7);

    // Bit assembly and byte strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            rsp_byte  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (rx_start) begin
                sh  <= {6'b0, cmd_i};
                cnt <= 3'd1;
            end else if (rx_en && rise_ev) begin
                sh  <= {sh[5:0], cmd_i};
                cnt <= cnt + 1'b1;
                if (cnt == 3'd7) begin
                    rsp_byte  <= {sh, cmd_i};
                    rsp_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sd_cmd_ctrl.sv
// Exchange sequencer: preamble, wait for line high, gap, transmit, turnaround,
// wait for start bit, receive, tail. Counts rising SD edges and reports the outcome.
// Assumes: start is honoured only in idle; lengths are latched at start.
module sd_cmd_ctrl
    import sd_cmd_pkg::*;
#(
    parameter int LEN_W    = 5,
    parameter int TIMEOUT  = 1024,
    parameter int PRE_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic             rise_ev,
    input  logic             cmd_i,
    input  logic             tx_last,
    input  logic             byte_end,
    output cmd_state_t       state,
    output logic [LEN_W-1:0] cmd_len_q,
    output logic             clk_en,
    output logic             tx_clr,
    output logic             tx_en,
    output logic             rx_start,
    output logic             rx_en,
    output logic             done,
    output logic [1:0]       result
);

    localparam int CNT_W = (TIMEOUT > PRE_CLKS) ? $clog2(TIMEOUT) : $clog2(PRE_CLKS);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CLKS - 1);
    localparam logic [CNT_W-1:0] TWO_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] bcnt;
    logic [LEN_W-1:0] rlen_q;

    // Control strobes decoded from the state
    assign clk_en   = (state != ST_IDLE);
    assign tx_clr   = (state == ST_IDLE) && start;
    assign tx_en    = (state == ST_TX);
    assign rx_en    = (state == ST_RX);
    assign rx_start = (state == ST_WAIT_LO) && rise_ev && !cmd_i;

    // Sequencer with shared edge counter and outcome register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bcnt      <= '0;
            rlen_q    <= '0;
            cmd_len_q <= '0;
            done      <= 1'b0;
            result    <= RES_OK;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_len_q <= cmd_len;
                        rlen_q    <= rsp_len;
                        cnt       <= '0;
                        state     <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (rise_ev) begin
                        if (cnt == PRE_LAST) begin
                            cnt   <= '0;
                            state <= ST_WAIT_HI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT_HI: begin
                    if (rise_ev) begin
                        if (cmd_i) begin
                            state <= ST_GAP;
                        end else if (cnt == TO_LAST) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            result <= RES_BUSY;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (rise_ev) begin
                        state <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (rise_ev && tx_last) begin
                        cnt   <= '0;
                        state <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    if (rise_ev) begin
                        if (cnt == TWO_LAST) begin
                            cnt <= '0;
                            if (rlen_q == '0) begin
                                state  <= ST_IDLE;
                                done   <= 1'b1;
                                result <= RES_OK;
                            end else begin
                                state <= ST_WAIT_LO;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT_LO: begin
                    if (rise_ev) begin
                        if (!cmd_i) begin
                            bcnt  <= '0;
                            state <= ST_RX;
                        end else if (cnt == TO_LAST) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            result <= RES_NORSP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (byte_end) begin
                        if (bcnt == rlen_q - 1'b1) begin
                            cnt   <= '0;
                            state <= ST_TAIL;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (rise_ev) begin
                        if (cnt == TWO_LAST) begin
                            state  <= ST_IDLE;
                            done   <= 1'b1;
                            result <= RES_OK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sd_cmd_xcvr.sv
// Top of the SD command-line transceiver: wires divider, sequencer,
// serializer and deserializer. Line is driven on falling and sampled on
// rising SD edges. Assumes clk_div, lengths and buffer stable during an exchange.
module sd_cmd_xcvr
    import sd_cmd_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int LEN_W    = 5,
    parameter int TIMEOUT  = 1024,
    parameter int PRE_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [7:0]       cmd_byte,
    output logic [LEN_W-1:0] cmd_idx,
    output logic [7:0]       rsp_byte,
    output logic             rsp_valid,
    output logic             done,
    output logic [1:0]       result,
    output logic             sd_clk,
    output logic             cmd_o,
    output logic             cmd_oe,
    input  logic             cmd_i
);

    cmd_state_t       state;
    logic [LEN_W-1:0] cmd_len_q;
    logic             clk_en, rise_ev, fall_ev;
    logic             tx_clr, tx_en, tx_last;
    logic             rx_start, rx_en, byte_end;

    // SD clock source
    sd_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en),
        .div     (clk_div),
        .sd_clk  (sd_clk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    // Exchange sequencer
    sd_cmd_ctrl #(
        .LEN_W    (LEN_W),
        .TIMEOUT  (TIMEOUT),
        .PRE_CLKS (PRE_CLKS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_len   (cmd_len),
        .rsp_len   (rsp_len),
        .rise_ev   (rise_ev),
        .cmd_i     (cmd_i),
        .tx_last   (tx_last),
        .byte_end  (byte_end),
        .state     (state),
        .cmd_len_q (cmd_len_q),
        .clk_en    (clk_en),
        .tx_clr    (tx_clr),
        .tx_en     (tx_en),
        .rx_start  (rx_start),
        .rx_en     (rx_en),
        .done      (done),
        .result    (result)
    );

    // Command serializer
    sd_cmd_tx #(.LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_clr),
        .tx_en    (tx_en),
        .fall_ev  (fall_ev),
        .cmd_byte (cmd_byte),
        .cmd_len  (cmd_len_q),
        .cmd_idx  (cmd_idx),
        .cmd_o    (cmd_o),
        .cmd_oe   (cmd_oe),
        .tx_last  (tx_last)
    );

    // Response deserializer
    sd_cmd_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_ev   (rise_ev),
        .rx_start  (rx_start),
        .rx_en     (rx_en),
        .cmd_i     (cmd_i),
        .rsp_byte  (rsp_byte),
        .rsp_valid (rsp_valid),
        .byte_end  (byte_end)
    );

endmodule

// File: rtl/sd_cmd_xcvr_chk.sv
// Protocol checker for sd_cmd_xcvr, bound to the top module.
// Assumes: state is the sequencer state visible in the top.
module sd_cmd_xcvr_chk
    import sd_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input cmd_state_t state,
    input logic       sd_clk,
    input logic       cmd_o,
    input logic       cmd_oe,
    input logic       rsp_valid,
    input logic       done,
    input logic [1:0] result
);

    // Drive enable only around transmission
    assert_oe_tx_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> (state == ST_TX || state == ST_TURN));

    // Driven bit changes only with a falling SD clock
    assert_drive_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && !$stable(cmd_o)) |-> $fell(sd_clk));

    // Clock held low once idle
    assert_idle_clk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !sd_clk);

    // Done is a single pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done carries a defined code and leaves the block idle
    assert_done_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3 && state == ST_IDLE));

    // Byte strobe only while receiving or just after the last byte
    assert_valid_in_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state == ST_RX || state == ST_TAIL));

endmodule

bind sd_cmd_xcvr sd_cmd_xcvr_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sd_clk    (sd_clk),
    .cmd_o     (cmd_o),
    .cmd_oe    (cmd_oe),
    .rsp_valid (rsp_valid),
    .done      (done),
    .result    (result)
);

// File: tb/sd_cmd_xcvr_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_xcvr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] cmd_len = '0;
    logic [4:0] rsp_len = '0;
    logic [7:0] clk_div = '0;
    logic [7:0] cmd_byte;
    logic [4:0] cmd_idx;
    logic [7:0] rsp_byte;
    logic       rsp_valid, done, sd_clk, cmd_o, cmd_oe, cmd_i;
    logic [1:0] result;
    logic       card_line = 1'b1;

    logic [7:0] cmd_buf [0:31];
    logic [7:0] rsp_buf [0:16];

    always #10 clk = ~clk;

    assign cmd_byte = cmd_buf[cmd_idx];
    assign cmd_i    = cmd_oe ? cmd_o : card_line;

    sd_cmd_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .rsp_len(rsp_len), .clk_div(clk_div), .cmd_byte(cmd_byte),
        .cmd_idx(cmd_idx), .rsp_byte(rsp_byte), .rsp_valid(rsp_valid),
        .done(done), .result(result), .sd_clk(sd_clk), .cmd_o(cmd_o),
        .cmd_oe(cmd_oe), .cmd_i(cmd_i)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Reference timeline, one entry per rising SD edge (index 0 unused)
    bit         e_oe[$];
    bit         e_o[$];
    bit         e_card[$];
    bit         e_vld[$];
    logic [7:0] e_byte[$];
    string      e_tag[$];
    int         done_rise;
    int         done_code;

    int  rc;
    int  half;
    bit  first_edge;
    bit  prev_clk;
    bit  seen_done;
    bit  active = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void add(bit oe, bit o, bit card, bit vld, logic [7:0] b, string tag);
        e_oe.push_back(oe);
        e_o.push_back(o);
        e_card.push_back(card);
        e_vld.push_back(vld);
        e_byte.push_back(b);
        e_tag.push_back(tag);
    endfunction

    // Build the expected edge-by-edge behaviour of one exchange
    function automatic void build(int L, int nlow, int nrsp, int d);
        e_oe.delete(); e_o.delete(); e_card.delete();
        e_vld.delete(); e_byte.delete(); e_tag.delete();
        add(0, 1, 1, 0, 0, "-");
        for (int r = 0; r < 8; r++) add(0, 1, (nlow > 0) ? 1'b0 : 1'b1, 0, 0, "R1");
        for (int k = 0; k < nlow && k < 1024; k++) add(0, 1, 0, 0, 0, "R2");
        if (nlow >= 1024) begin
            done_rise = e_oe.size() - 1; done_code = 1; return;
        end
        add(0, 1, 1, 0, 0, "R2");
        add(0, 1, 1, 0, 0, "R3");
        for (int i = 0; i < L; i++)
            for (int b = 7; b >= 0; b--) add(1, cmd_buf[i][b], 1, 0, 0, "R4");
        add(0, 1, 1, 0, 0, "R5");
        add(0, 1, 1, 0, 0, "R5");
        if (nrsp == 0) begin
            done_rise = e_oe.size() - 1; done_code = 0; return;
        end
        for (int k = 0; k < d && k < 1024; k++) add(0, 1, 1, 0, 0, "R6");
        if (d >= 1024) begin
            done_rise = e_oe.size() - 1; done_code = 2; return;
        end
        for (int j = 0; j < nrsp; j++)
            for (int b = 7; b >= 0; b--)
                add(0, 1, rsp_buf[j][b], (b == 0), rsp_buf[j], "R7");
        add(0, 1, 1, 0, 0, "R8");
        add(0, 1, 1, 0, 0, "R8");
        done_rise = e_oe.size() - 1;
        done_code = 0;
    endfunction

    // Per-cycle comparison against the reference timeline
    always @(negedge clk) begin
        if (active) begin
            if (sd_clk !== prev_clk) begin
                if (!first_edge && !seen_done)
                    chk(half == int'(clk_div) + 1, "R9 half-period", half, int'(clk_div) + 1);
                first_edge = 1'b0;
                half = 1;
            end else begin
                half++;
            end
            if (sd_clk && !prev_clk) begin
                rc++;
                if (rc >= e_oe.size()) begin
                    chk(0, "R11 extra SD clock", rc, e_oe.size() - 1);
                end else begin
                    chk(cmd_oe == e_oe[rc], {e_tag[rc], " cmd_oe"}, cmd_oe, e_oe[rc]);
                    if (e_oe[rc])
                        chk(cmd_o == e_o[rc], {e_tag[rc], " cmd_o"}, cmd_o, e_o[rc]);
                    else
                        chk(cmd_o == 1'b1, "R10 released value", cmd_o, 1);
                    chk(rsp_valid == e_vld[rc], "R7 rsp_valid", rsp_valid, e_vld[rc]);
                    if (e_vld[rc])
                        chk(rsp_byte == e_byte[rc], "R7 rsp_byte", rsp_byte, e_byte[rc]);
                    chk(done == (rc == done_rise), "R11 done timing", done, rc == done_rise);
                    if (done)
                        chk(result == done_code[1:0],
                            (done_code == 1) ? "R2 result" : (done_code == 2) ? "R6 result" : "R5 R8 result",
                            result, done_code);
                end
                card_line = (rc + 1 < e_card.size()) ? e_card[rc + 1] : 1'b1;
            end else begin
                chk(!rsp_valid, "R7 stray rsp_valid", rsp_valid, 0);
                chk(!done, "R11 stray done", done, 0);
            end
            if (done) seen_done = 1'b1;
            prev_clk = sd_clk;
        end
    end

    task automatic run(input int div, input int L, input int nlow, input int nrsp, input int d);
        int guard;
        clk_div = 8'(div);
        cmd_len = 5'(L);
        rsp_len = 5'(nrsp);
        build(L, nlow, nrsp, d);
        rc = 0; half = 0; first_edge = 1'b1; seen_done = 1'b0;
        prev_clk = sd_clk;
        card_line = e_card[1];
        @(negedge clk);
        active = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!seen_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(seen_done, "R11 done seen", seen_done, 1);
        repeat (4) @(negedge clk);
        active = 1'b0;
        chk(rc == done_rise, "R11 edge count", rc, done_rise);
        chk(sd_clk == 1'b0, "R9 idle clock low", sd_clk, 0);
        chk(cmd_oe == 1'b0, "R10 idle released", cmd_oe, 0);
        card_line = 1'b1;
    endtask

    initial begin
        #(150000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) cmd_buf[i] = 8'((i * 53 + 17) & 255);
        for (int i = 0; i < 17; i++) rsp_buf[i] = 8'((i * 37 + 3) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R9 R10 R11)
        chk(sd_clk == 1'b0, "R9 reset sd_clk", sd_clk, 0);
        chk(cmd_oe == 1'b0, "R10 reset cmd_oe", cmd_oe, 0);
        chk(done == 1'b0, "R11 reset done", done, 0);
        chk(rsp_valid == 1'b0, "R7 reset rsp_valid", rsp_valid, 0);

        // Six-byte command, brief busy, six-byte response
        cmd_buf[0] = 8'h51; cmd_buf[5] = 8'h55;
        rsp_buf[0] = 8'h11; rsp_buf[5] = 8'h67;
        run(1, 6, 3, 6, 5);
        // No response requested (R5)
        run(0, 6, 0, 0, 0);
        // Card holds line low through the whole wait (R2)
        run(0, 6, 1024, 1, 0);
        // Line released on the last allowed sample, one-byte command (R2 R3)
        rsp_buf[0] = 8'h3F;
        run(0, 1, 1023, 1, 0);
        // No start bit ever (R6)
        run(0, 6, 0, 6, 1024);
        // Longest response, start bit on the last allowed sample (R6 R7 R8)
        rsp_buf[0] = 8'h24;
        run(2, 6, 0, 17, 1023);
        // Immediate start bit with a slow clock
        rsp_buf[0] = 8'h00; rsp_buf[1] = 8'hFF;
        run(3, 2, 2, 2, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule